// File: doc/BRIEF.md
# Unprivileged Load/Store Address Generator

This block sits in the address stage of a 32-bit load/store pipeline and serves only the "translate as user" family of accesses. From a base register value and either a short immediate or a shifted register operand, it produces the effective memory address, the value to write back to the base register, byte-lane strobes and lane-replicated store data. Every access it emits carries a forced-unprivileged attribute, so permission checks downstream run as for user code even when the core is in a privileged mode. An access made from user mode therefore behaves exactly like an ordinary load or store.

Two addressing forms are supported. In the offset form, the address is the base plus a small unsigned immediate, and the base register is not changed. In the post-indexed form, the access uses the unmodified base, and the base plus or minus the offset is written back. Each form and access class has its own limits on the offset and the shift. Any request outside those limits sets an illegal-encoding flag and suppresses writeback.

Results are held in a one-entry output slot governed by a two-state machine. In `SLOT_EMPTY` the stage accepts a request (transition ACCEPT). In `SLOT_FULL` it holds the result while the consumer stalls (HOLD). When the consumer takes the result and a new request is present, the slot is replaced in one cycle (REFILL). When the consumer takes the result and no request is present, the slot returns to empty (DRAIN).

Top module: `ulsag_top`

## Requirements
- R1: `unpriv` is 1 in every cycle in which `out_valid` is 1.
- R2: With `post_idx`=0 (offset form), `addr` = `base` + `imm` and `wb_en` = 0. The request is illegal if `imm` > 255, if `use_reg` = 1, or if `add_sub` = 0 (subtract). `add_sub`=1 means add.
- R3: With `post_idx`=1, `addr` equals the unmodified `base`, and `wb_val` = `base` + offset when `add_sub`=1, or `base` − offset when `add_sub`=0.
- R4: A post-indexed immediate (`use_reg`=0) may be up to 4095 for a word access or an unsigned byte access, and up to 255 for every other access. Larger values are illegal.
- R5: For a word access or an unsigned byte access with a register offset, `shift_kind` is encoded as LSL=0, LSR=1, ASR=2, ROR=3, RRX=4. The legal amounts are LSL 0–31, LSR 1–32, ASR 1–32 and ROR 1–31. The amount is ignored for RRX. Any other code or amount is illegal.
- R6: LSR by 32 gives an offset of 0. ASR by 32 gives 32 copies of bit 31 of `rm_val`. RRX gives {`carry_in`, `rm_val`[31:1]}.
- R7: For a halfword access or a signed access with a register offset, any request other than LSL by 0 is illegal. Without a shift, the register is added or subtracted as given.
- R8: A register offset whose index `rm_idx` is 15 is illegal.
- R9: `size` is encoded as 0=byte, 1=halfword, 2=word; the value 3 is illegal. `signed_ld`=1 is legal only when `is_load`=1 and `size` is not word.
- R10: `wb_en` is 1 only for a legal post-indexed request.
- R11: `strobe` is little-endian: a byte access sets bit `addr`[1:0]; a halfword access sets bits 1:0 when `addr`[1]=0 and bits 3:2 when it is 1; a word access sets all four bits. `wr_data` repeats `st_data`[7:0] four times for a byte and `st_data`[15:0] twice for a halfword, and equals `st_data` for a word.
- R12: After reset, `out_valid`=0 and `in_ready`=1. A request is taken when `in_valid` and `in_ready` are both 1, and its results appear with `out_valid`=1 after one clock edge. While `out_valid`=1 and `out_ready`=0, the outputs hold steady and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Stage can accept a request |
| base | input | 32 | Base register value |
| post_idx | input | 1 | 1 = post-indexed form, 0 = offset form |
| use_reg | input | 1 | 1 = register offset, 0 = immediate |
| add_sub | input | 1 | 1 = add offset, 0 = subtract |
| imm | input | 12 | Immediate magnitude |
| rm_idx | input | 4 | Index of the offset register |
| rm_val | input | 32 | Value of the offset register |
| shift_kind | input | 3 | Shift type code |
| shift_amt | input | 6 | Shift amount |
| carry_in | input | 1 | Carry used by RRX |
| size | input | 2 | Access size code |
| signed_ld | input | 1 | Signed access |
| is_load | input | 1 | 1 = load, 0 = store |
| st_data | input | 32 | Store data, right-aligned |
| out_valid | output | 1 | Result slot full |
| out_ready | input | 1 | Consumer takes the result |
| addr | output | 32 | Effective address |
| wb_val | output | 32 | Base writeback value |
| wb_en | output | 1 | Writeback enable |
| strobe | output | 4 | Byte-lane enables |
| wr_data | output | 32 | Lane-replicated store data |
| unpriv | output | 1 | Forced-unprivileged attribute |
| illegal | output | 1 | Illegal-encoding flag |

## Verification
The hardest path to reach is the REFILL transition. It needs a result that is stalled in the slot, a second request already waiting, and `out_ready` rising, all at the same time. The stimulus first fills the slot with `out_ready` low and presents a different request while the slot is full. It checks that this request is refused and that the held outputs do not change. It then raises `out_ready` with the request still present and expects the second result in the very next cycle. The shift extremes (amount 32 for LSR and ASR, and RRX with a carry) and the per-class immediate limits are driven from the vector table at their exact boundaries.

// File: rtl/ulsag_pkg.sv
package ulsag_pkg;
    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } shift_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;
endpackage

// File: rtl/ulsag_shift.sv
module ulsag_shift
    import ulsag_pkg::*;
#(
    parameter int W       = 32,
    parameter int SHAMT_W = 6
) (
    input  logic [W-1:0]       val,
    input  logic [2:0]         kind,
    input  logic [SHAMT_W-1:0] amt,
    input  logic               cin,
    output logic [W-1:0]       res
);
    localparam int RW = $clog2(W);

    logic [2*W-1:0] zext, sext, dbl;
    logic [2*W-1:0] lsr_full, asr_full, ror_full;

    always_comb begin
        zext     = {{W{1'b0}}, val};
        sext     = {{W{val[W-1]}}, val};
        dbl      = {val, val};
        lsr_full = zext >> amt;
        asr_full = sext >> amt;
        ror_full = dbl >> amt[RW-1:0];
        unique case (shift_e'(kind))
            SH_LSL:  res = val << amt[RW-1:0];
            SH_LSR:  res = lsr_full[W-1:0];
            SH_ASR:  res = asr_full[W-1:0];
            SH_ROR:  res = ror_full[W-1:0];
            SH_RRX:  res = {cin, val[W-1:1]};
            default: res = val;
        endcase
    end
endmodule

// File: rtl/ulsag_rules.sv
module ulsag_rules
    import ulsag_pkg::*;
#(
    parameter int W          = 32,
    parameter int IMM_W      = 12,
    parameter int SHAMT_W    = 6,
    parameter int IDX_W      = 4,
    parameter int NARROW_MAX = 255,
    parameter int WIDE_MAX   = 4095,
    parameter int PC_IDX     = 15
) (
    input  logic               post_idx,
    input  logic               use_reg,
    input  logic               add_sub,
    input  logic [1:0]         size,
    input  logic               signed_ld,
    input  logic               is_load,
    input  logic [2:0]         kind,
    input  logic [SHAMT_W-1:0] amt,
    input  logic [IDX_W-1:0]   rm_idx,
    input  logic [IMM_W-1:0]   imm,
    output logic               illegal
);
    localparam logic [IMM_W-1:0]   NARROW_LIM = IMM_W'(NARROW_MAX);
    localparam logic [IMM_W-1:0]   WIDE_LIM   = IMM_W'(WIDE_MAX);
    localparam logic [SHAMT_W-1:0] AMT_TOP    = SHAMT_W'(W);
    localparam logic [SHAMT_W-1:0] AMT_TOPM1  = SHAMT_W'(W - 1);
    localparam logic [IDX_W-1:0]   PC_CODE    = IDX_W'(PC_IDX);

    logic wide_class, bad_size, bad_sign, bad_form, bad_shift;

    always_comb begin
        wide_class = (size_e'(size) == SZ_WORD) ||
                     (size_e'(size) == SZ_BYTE && !signed_ld);
        bad_size   = (size_e'(size) == SZ_RSVD);
        bad_sign   = signed_ld && (!is_load || size_e'(size) == SZ_WORD);
        bad_shift  = 1'b0;
        if (wide_class) begin
            unique case (shift_e'(kind))
                SH_LSL:  bad_shift = amt > AMT_TOPM1;
                SH_LSR:  bad_shift = (amt == '0) || (amt > AMT_TOP);
                SH_ASR:  bad_shift = (amt == '0) || (amt > AMT_TOP);
                SH_ROR:  bad_shift = (amt == '0) || (amt > AMT_TOPM1);
                SH_RRX:  bad_shift = 1'b0;
                default: bad_shift = 1'b1;
            endcase
        end else begin
            bad_shift = (shift_e'(kind) != SH_LSL) || (amt != '0);
        end

        if (!post_idx)
            bad_form = use_reg || !add_sub || (imm > NARROW_LIM);
        else if (!use_reg)
            bad_form = imm > (wide_class ? WIDE_LIM : NARROW_LIM);
        else
            bad_form = (rm_idx == PC_CODE) || bad_shift;

        illegal = bad_size || bad_sign || bad_form;
    end
endmodule

// File: rtl/ulsag_lanes.sv
module ulsag_lanes
    import ulsag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]   addr,
    input  logic [1:0]     size,
    input  logic [W-1:0]   st_data,
    output logic [W/8-1:0] strobe,
    output logic [W-1:0]   wr_data
);
    localparam int LANES = W / 8;
    localparam int LB    = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [LB-1:0]   LANE_ID = LB'(i);
        localparam logic [LB-2:0]   PAIR_ID = LANE_ID[LB-1:1];
        always_comb begin
            unique case (size_e'(size))
                SZ_BYTE: begin
                    strobe[i]          = (addr[LB-1:0] == LANE_ID);
                    wr_data[8*i +: 8]  = st_data[7:0];
                end
                SZ_HALF: begin
                    strobe[i]          = (addr[LB-1:1] == PAIR_ID);
                    wr_data[8*i +: 8]  = st_data[8*(i%2) +: 8];
                end
                default: begin
                    strobe[i]          = 1'b1;
                    wr_data[8*i +: 8]  = st_data[8*i +: 8];
                end
            endcase
        end
    end

    // R11
    always_comb begin
        if (size_e'(size) == SZ_BYTE)
            lane_onehot_chk: assert ($countones(strobe) == 1);
    end
endmodule

// File: rtl/ulsag_top.sv
module ulsag_top
    import ulsag_pkg::*;
#(
    parameter int W          = 32,
    parameter int IMM_W      = 12,
    parameter int IDX_W      = 4,
    parameter int NARROW_MAX = 255,
    parameter int WIDE_MAX   = 4095,
    parameter int PC_IDX     = 15
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [W-1:0]              base,
    input  logic                      post_idx,
    input  logic                      use_reg,
    input  logic                      add_sub,
    input  logic [IMM_W-1:0]          imm,
    input  logic [IDX_W-1:0]          rm_idx,
    input  logic [W-1:0]              rm_val,
    input  logic [2:0]                shift_kind,
    input  logic [$clog2(W):0]        shift_amt,
    input  logic                      carry_in,
    input  logic [1:0]                size,
    input  logic                      signed_ld,
    input  logic                      is_load,
    input  logic [W-1:0]              st_data,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [W-1:0]              addr,
    output logic [W-1:0]              wb_val,
    output logic                      wb_en,
    output logic [W/8-1:0]            strobe,
    output logic [W-1:0]              wr_data,
    output logic                      unpriv,
    output logic                      illegal
);
    localparam int SHAMT_W = $clog2(W) + 1;
    localparam int LANES   = W / 8;

    slot_e state, state_nx;
    logic  take;
    logic  [W-1:0]     shifted, offset, sum, addr_nx;
    logic  [LANES-1:0] strobe_nx;
    logic  [W-1:0]     wdata_nx;
    logic              bad_nx;

    ulsag_shift #(.W(W), .SHAMT_W(SHAMT_W)) u_shift (
        .val(rm_val), .kind(shift_kind), .amt(shift_amt),
        .cin(carry_in), .res(shifted)
    );

    ulsag_rules #(
        .W(W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W), .IDX_W(IDX_W),
        .NARROW_MAX(NARROW_MAX), .WIDE_MAX(WIDE_MAX), .PC_IDX(PC_IDX)
    ) u_rules (
        .post_idx(post_idx), .use_reg(use_reg), .add_sub(add_sub),
        .size(size), .signed_ld(signed_ld), .is_load(is_load),
        .kind(shift_kind), .amt(shift_amt), .rm_idx(rm_idx),
        .imm(imm), .illegal(bad_nx)
    );

    always_comb begin
        offset  = use_reg ? shifted : {{(W-IMM_W){1'b0}}, imm};
        sum     = add_sub ? base + offset : base - offset;
        addr_nx = post_idx ? base : sum;
    end

    ulsag_lanes #(.W(W)) u_lanes (
        .addr(addr_nx), .size(size), .st_data(st_data),
        .strobe(strobe_nx), .wr_data(wdata_nx)
    );

    // Slot control: ACCEPT, HOLD, REFILL, DRAIN
    assign in_ready  = (state == SLOT_EMPTY) || out_ready;
    assign take      = in_valid && in_ready;
    assign out_valid = (state == SLOT_FULL);

    always_comb begin
        state_nx = state;
        unique case (state)
            SLOT_EMPTY: if (in_valid)                state_nx = SLOT_FULL;
            SLOT_FULL:  if (out_ready && !in_valid)  state_nx = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLOT_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr    <= '0;
            wb_val  <= '0;
            wb_en   <= 1'b0;
            strobe  <= '0;
            wr_data <= '0;
            unpriv  <= 1'b0;
            illegal <= 1'b0;
        end else if (take) begin
            addr    <= addr_nx;
            wb_val  <= sum;
            wb_en   <= post_idx && !bad_nx;
            strobe  <= strobe_nx;
            wr_data <= wdata_nx;
            unpriv  <= 1'b1;
            illegal <= bad_nx;
        end
    end

    // R1
    unpriv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> unpriv);

    // R10
    wb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wb_en) |-> !illegal);

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(addr) && $stable(wb_val)));

    // R12
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
endmodule

// File: tb/sim_ulsag_top.sv
module sim_ulsag_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready, out_valid, out_ready;
    logic [31:0] base, rm_val, st_data, addr, wb_val, wr_data;
    logic        post_idx, use_reg, add_sub, carry_in, signed_ld, is_load;
    logic [11:0] imm;
    logic [3:0]  rm_idx, strobe;
    logic [2:0]  shift_kind;
    logic [5:0]  shift_amt;
    logic [1:0]  size;
    logic        wb_en, unpriv, illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ulsag_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .base(base), .post_idx(post_idx), .use_reg(use_reg), .add_sub(add_sub),
        .imm(imm), .rm_idx(rm_idx), .rm_val(rm_val), .shift_kind(shift_kind),
        .shift_amt(shift_amt), .carry_in(carry_in), .size(size),
        .signed_ld(signed_ld), .is_load(is_load), .st_data(st_data),
        .out_valid(out_valid), .out_ready(out_ready), .addr(addr),
        .wb_val(wb_val), .wb_en(wb_en), .strobe(strobe), .wr_data(wr_data),
        .unpriv(unpriv), .illegal(illegal)
    );

    typedef struct packed {
        logic        post;
        logic        ureg;
        logic        add;
        logic [1:0]  sz;
        logic        sgn;
        logic        ld;
        logic [2:0]  kind;
        logic [5:0]  amt;
        logic [3:0]  rm;
        logic [11:0] im;
        logic [31:0] b;
        logic [31:0] rv;
        logic        cin;
        logic [31:0] e_addr;
        logic [31:0] e_wb;
        logic        e_ill;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b1,2'd2,1'b0,1'b0,3'd0,6'd0, 4'd0, 12'h010,32'h1000,32'h0,       1'b0,32'h1000+32'h10,32'h0,       1'b0},
        '{1'b0,1'b0,1'b1,2'd2,1'b0,1'b0,3'd0,6'd0, 4'd0, 12'h100,32'h1000,32'h0,       1'b0,32'h1100,       32'h0,       1'b1},
        '{1'b1,1'b0,1'b1,2'd2,1'b0,1'b0,3'd0,6'd0, 4'd0, 12'hFFF,32'h2000,32'h0,       1'b0,32'h2000,       32'h2FFF,    1'b0},
        '{1'b1,1'b0,1'b0,2'd2,1'b0,1'b0,3'd0,6'd0, 4'd0, 12'h010,32'h2000,32'h0,       1'b0,32'h2000,       32'h1FF0,    1'b0},
        '{1'b1,1'b0,1'b1,2'd1,1'b0,1'b0,3'd0,6'd0, 4'd0, 12'h100,32'h2000,32'h0,       1'b0,32'h2000,       32'h0,       1'b1},
        '{1'b1,1'b0,1'b1,2'd0,1'b0,1'b1,3'd0,6'd0, 4'd0, 12'hFFF,32'h0,   32'h0,       1'b0,32'h0,          32'hFFF,     1'b0},
        '{1'b1,1'b1,1'b1,2'd2,1'b0,1'b0,3'd0,6'd4, 4'd2, 12'h000,32'h100, 32'h3,       1'b0,32'h100,        32'h130,     1'b0},
        '{1'b1,1'b1,1'b1,2'd2,1'b0,1'b0,3'd1,6'd32,4'd2, 12'h000,32'h100, 32'hFFFFFFFF,1'b0,32'h100,        32'h100,     1'b0},
        '{1'b1,1'b1,1'b0,2'd2,1'b0,1'b0,3'd2,6'd32,4'd2, 12'h000,32'h100, 32'h80000000,1'b0,32'h100,        32'h101,     1'b0},
        '{1'b1,1'b1,1'b1,2'd2,1'b0,1'b0,3'd3,6'd8, 4'd2, 12'h000,32'h0,   32'hAB,      1'b0,32'h0,          32'hAB000000,1'b0},
        '{1'b1,1'b1,1'b1,2'd2,1'b0,1'b0,3'd4,6'd0, 4'd2, 12'h000,32'h0,   32'h2,       1'b1,32'h0,          32'h80000001,1'b0},
        '{1'b1,1'b1,1'b1,2'd2,1'b0,1'b0,3'd0,6'd0, 4'd15,12'h000,32'h100, 32'h4,       1'b0,32'h100,        32'h0,       1'b1},
        '{1'b1,1'b1,1'b1,2'd1,1'b0,1'b1,3'd0,6'd1, 4'd2, 12'h000,32'h100, 32'h4,       1'b0,32'h100,        32'h0,       1'b1},
        '{1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,3'd0,6'd0, 4'd0, 12'h000,32'h40,  32'h0,       1'b0,32'h40,         32'h0,       1'b1},
        '{1'b1,1'b1,1'b1,2'd2,1'b0,1'b0,3'd1,6'd0, 4'd2, 12'h000,32'h100, 32'h4,       1'b0,32'h100,        32'h0,       1'b1},
        '{1'b0,1'b0,1'b0,2'd2,1'b0,1'b0,3'd0,6'd0, 4'd0, 12'h004,32'h40,  32'h0,       1'b0,32'h3C,         32'h0,       1'b1},
        '{1'b1,1'b1,1'b0,2'd1,1'b1,1'b1,3'd0,6'd0, 4'd3, 12'h000,32'h10,  32'h6,       1'b0,32'h10,         32'hA,       1'b0},
        '{1'b1,1'b1,1'b1,2'd2,1'b0,1'b0,3'd0,6'd31,4'd2, 12'h000,32'h0,   32'h1,       1'b0,32'h0,          32'h80000000,1'b0}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1, 15:     return "R2";
            3:            return "R3";
            2, 4, 5:      return "R4";
            6, 9, 14, 17: return "R5";
            7, 8, 10:     return "R6";
            11:           return "R8";
            12, 16:       return "R7";
            13:           return "R9";
            default:      return "R?";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 0; out_ready = 1; base = 0; post_idx = 0; use_reg = 0;
        add_sub = 1; imm = 0; rm_idx = 0; rm_val = 0; shift_kind = 0;
        shift_amt = 0; carry_in = 0; size = 2; signed_ld = 0; is_load = 0;
        st_data = 0;
    endtask

    task automatic drive_vec(vec_t v);
        post_idx = v.post; use_reg = v.ureg; add_sub = v.add; size = v.sz;
        signed_ld = v.sgn; is_load = v.ld; shift_kind = v.kind;
        shift_amt = v.amt; rm_idx = v.rm; imm = v.im; base = v.b;
        rm_val = v.rv; carry_in = v.cin;
    endtask

    task automatic send_store(logic [1:0] sz, logic [11:0] off, logic [31:0] d);
        @(negedge clk);
        idle_inputs();
        base = 32'h1000; imm = off; size = sz; st_data = d; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12 reset state
        check("R12", "out_valid after reset", {31'b0, out_valid}, 32'd0);
        check("R12", "in_ready after reset",  {31'b0, in_ready},  32'd1);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle_inputs();
            drive_vec(TBL[i]);
            in_valid = 1;
            @(negedge clk);
            in_valid = 0;
            check(tag_of(i), $sformatf("vec %0d illegal", i), {31'b0, illegal}, {31'b0, TBL[i].e_ill});
            check(tag_of(i), $sformatf("vec %0d addr", i), addr, TBL[i].e_addr);
            check("R10", $sformatf("vec %0d wb_en", i), {31'b0, wb_en},
                  {31'b0, TBL[i].post && !TBL[i].e_ill});
            if (TBL[i].post && !TBL[i].e_ill)
                check(tag_of(i), $sformatf("vec %0d wb_val", i), wb_val, TBL[i].e_wb);
            check("R1", $sformatf("vec %0d unpriv", i), {31'b0, unpriv}, 32'd1);
        end

        // R11 byte lanes at every offset
        for (int k = 0; k < 4; k++) begin
            send_store(2'd0, 12'(k), 32'h11223344);
            check("R11", $sformatf("byte strobe off %0d", k), {28'b0, strobe}, 32'(1 << k));
            check("R11", "byte wr_data", wr_data, 32'h44444444);
        end
        send_store(2'd1, 12'd2, 32'h11223344);
        check("R11", "half strobe upper", {28'b0, strobe}, 32'hC);
        check("R11", "half wr_data", wr_data, 32'h33443344);
        send_store(2'd1, 12'd0, 32'h11223344);
        check("R11", "half strobe lower", {28'b0, strobe}, 32'h3);
        send_store(2'd2, 12'd0, 32'h11223344);
        check("R11", "word strobe", {28'b0, strobe}, 32'hF);
        check("R11", "word wr_data", wr_data, 32'h11223344);

        // R9 reserved size code
        @(negedge clk);
        idle_inputs(); size = 2'd3; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        check("R9", "size 3 illegal", {31'b0, illegal}, 32'd1);

        // R12 stall, refused request, then refill
        @(negedge clk);
        idle_inputs(); base = 32'hA000; imm = 12'h8; in_valid = 1; out_ready = 0;
        @(negedge clk);
        base = 32'hB000; imm = 12'h4;
        check("R12", "in_ready while stalled", {31'b0, in_ready}, 32'd0);
        @(negedge clk);
        check("R12", "held addr", addr, 32'hA008);
        check("R12", "still valid", {31'b0, out_valid}, 32'd1);
        out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        check("R12", "refill addr", addr, 32'hB004);
        check("R12", "refill valid", {31'b0, out_valid}, 32'd1);
        @(negedge clk);
        check("R12", "drained", {31'b0, out_valid}, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule